// File: doc/BRIEF.md
# Synchronized Start Gate for Multi-Unit Sample Streaming

This block holds back the sample streams of one radio unit until a shared start signal arrives. Several units run from a common sample clock and share one active-low trigger wire. Each unit places the block between its sample FIFOs and its converter interface. When the wire is pulled low, every unit lets samples through on the same sample clock edge. Until then, the transmit datapath sees an empty FIFO, receive samples are dropped, and the sample timestamp counter is held.

One unit acts as master. Software sets its fire bit, and the master then pulls the wire low through an open-drain output enable. Every other unit is a slave and only senses the wire. The master sees its own pulse through the same two-flop synchronizer as the slaves, so all units release with the same latency.

A sticky fired flag keeps the paths open after the pulse ends. Clearing the enable bit disarms the block and clears that flag. With the enable bit clear, all three gated signals pass through untouched.

Top module: `sync_start_gate`

## Requirements
- R1: After reset, `fired_o`, `line_asserted_o` and `trig_oe_o` are all 0.
- R2: While `en_i` is 0, `tx_empty_o` equals `tx_empty_i`, `rx_we_o` equals `rx_we_i` and `ts_en_o` equals `ts_en_i`.
- R3: While `en_i` is 1 and `fired_o` is 0, `tx_empty_o` is 1 (empty).
- R4: While `en_i` is 1 and `fired_o` is 0, `rx_we_o` is 0.
- R5: While `en_i` is 1 and `fired_o` is 0, `ts_en_o` is 0.
- R6: `trig_oe_o` is 1 (wire pulled low) in the cycle after a clock edge at which `en_i`, `master_i` and `fire_i` were all 1, and is 0 otherwise. A slave (`master_i` = 0) never drives the wire.
- R7: Assume `trig_n_i` is low before clock edge k. Then `line_asserted_o` becomes 1 after edge k+1. If `en_i` is 1, `fired_o` becomes 1 after edge k+2. A master with an open-drain loopback fires one edge later than this, because of its registered output enable.
- R8: Once set, `fired_o` stays 1 while `en_i` stays 1, even if the wire returns high. It clears at the first edge that samples `en_i` = 0.
- R9: The edge that sets `fired_o` also releases all three gates: `tx_empty_o`, `rx_we_o` and `ts_en_o` then follow their inputs.
- R10: A master and a slave on the same wire set `fired_o` in the same cycle.
- R11: A low wire level seen while `en_i` is 0 does not set `fired_o`. If the wire is still low when `en_i` rises, `fired_o` sets at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable (arm) bit from software |
| master_i | input | 1 | Role bit: 1 = master, 0 = slave |
| fire_i | input | 1 | Master fire bit from software |
| trig_n_i | input | 1 | Shared trigger wire, active-low, asynchronous |
| trig_oe_o | output | 1 | Open-drain enable; 1 pulls the wire low |
| tx_empty_i | input | 1 | TX FIFO empty flag from the FIFO |
| tx_empty_o | output | 1 | Empty flag presented to the transmit datapath |
| rx_we_i | input | 1 | RX FIFO write enable from the converter side |
| rx_we_o | output | 1 | Gated RX FIFO write enable |
| ts_en_i | input | 1 | Timestamp counter increment enable |
| ts_en_o | output | 1 | Gated timestamp increment enable |
| line_asserted_o | output | 1 | Synchronized wire level; 1 = wire low |
| fired_o | output | 1 | Sticky fired status |

## Verification
The hardest state to reach is a master and a slave releasing in the same cycle. That needs an open-drain wire that both units drive and sense. The bench therefore models the wire as a wired-AND with a pull-up, driven by a master instance, a slave instance and an external pull-down. It then checks the exact edge counts from the fire bit and from an external pulse. A second hard case is a wire that is already low while the block is disarmed. The bench reaches it by holding the external pull-down, then raising the enable later.

// File: rtl/sync_start_pkg.sv
package sync_start_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic en;
    logic master;
    logic fire;
  } start_ctrl_t;
endpackage

// File: rtl/trig_synchronizer.sv
module trig_synchronizer #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= IDLE;
          else         chain_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= IDLE;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/trig_fire_ctrl.sv
module trig_fire_ctrl
  import sync_start_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  start_ctrl_t ctrl_i,
  input  logic        line_sync_i,
  output logic        drive_o,
  output logic        fired_o
);
  logic drive_q, fired_q;

  // registered open-drain enable keeps the shared wire glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= ctrl_i.en & ctrl_i.master & ctrl_i.fire;
  end

  // sticky fire flag, cleared only by disarm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fired_q <= 1'b0;
    else if (!ctrl_i.en)   fired_q <= 1'b0;
    else if (!line_sync_i) fired_q <= 1'b1;
  end

  assign drive_o = drive_q;
  assign fired_o = fired_q;
endmodule

// File: rtl/start_gate.sv
module start_gate (
  input  logic hold_i,
  input  logic tx_empty_i,
  input  logic rx_we_i,
  input  logic ts_en_i,
  output logic tx_empty_o,
  output logic rx_we_o,
  output logic ts_en_o
);
  always_comb begin
    tx_empty_o = tx_empty_i | hold_i;
    rx_we_o    = rx_we_i & ~hold_i;
    ts_en_o    = ts_en_i & ~hold_i;
  end
endmodule

// File: rtl/sync_start_gate.sv
module sync_start_gate
  import sync_start_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic master_i,
  input  logic fire_i,
  input  logic trig_n_i,
  output logic trig_oe_o,
  input  logic tx_empty_i,
  output logic tx_empty_o,
  input  logic rx_we_i,
  output logic rx_we_o,
  input  logic ts_en_i,
  output logic ts_en_o,
  output logic line_asserted_o,
  output logic fired_o
);
  start_ctrl_t ctrl;
  logic        line_sync;
  logic        fired;
  logic        hold;

  assign ctrl = '{en: en_i, master: master_i, fire: fire_i};

  trig_synchronizer #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(trig_n_i),
    .sync_o (line_sync)
  );

  trig_fire_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .line_sync_i(line_sync),
    .drive_o    (trig_oe_o),
    .fired_o    (fired)
  );

  assign hold = en_i & ~fired;

  start_gate u_gate (
    .hold_i    (hold),
    .tx_empty_i(tx_empty_i),
    .rx_we_i   (rx_we_i),
    .ts_en_i   (ts_en_i),
    .tx_empty_o(tx_empty_o),
    .rx_we_o   (rx_we_o),
    .ts_en_o   (ts_en_o)
  );

  assign line_asserted_o = ~line_sync;
  assign fired_o         = fired;
endmodule

// File: rtl/sync_start_gate_chk.sv
module sync_start_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic fire_i,
  input logic trig_oe_o,
  input logic tx_empty_i,
  input logic tx_empty_o,
  input logic rx_we_i,
  input logic rx_we_o,
  input logic ts_en_i,
  input logic ts_en_o,
  input logic line_asserted_o,
  input logic fired_o
);
  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (tx_empty_o == tx_empty_i && rx_we_o == rx_we_i && ts_en_o == ts_en_i));

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fired_o) |-> tx_empty_o);

  p_rx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fired_o) |-> !rx_we_o);

  p_ts_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fired_o) |-> !ts_en_o);

  p_slave_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !trig_oe_o);

  p_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && fire_i) |=> trig_oe_o);

  p_fire_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fired_o) |-> $past(line_asserted_o));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_o && en_i) |=> fired_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fired_o);

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fired_o) |-> (tx_empty_o == tx_empty_i && rx_we_o == rx_we_i && ts_en_o == ts_en_i));
endmodule

bind sync_start_gate sync_start_gate_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .master_i       (master_i),
  .fire_i         (fire_i),
  .trig_oe_o      (trig_oe_o),
  .tx_empty_i     (tx_empty_i),
  .tx_empty_o     (tx_empty_o),
  .rx_we_i        (rx_we_i),
  .rx_we_o        (rx_we_o),
  .ts_en_i        (ts_en_i),
  .ts_en_o        (ts_en_o),
  .line_asserted_o(line_asserted_o),
  .fired_o        (fired_o)
);

// File: tb/sim_sync_start_gate.sv
`timescale 1ns/1ps
module sim_sync_start_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en0 = 0, ms0 = 0, fi0 = 0;
  logic en1 = 0, fi1 = 0;
  logic ext_low = 0;
  logic txe = 1, rxwe = 0, tse = 0;
  logic oe0, oe1, line_n;
  logic txe0, rxwe0, tse0, la0, fd0;
  logic txe1, rxwe1, tse1, la1, fd1;

  // open-drain wire with pull-up
  assign line_n = ~(oe0 | oe1 | ext_low);

  int checks = 0;
  int fails  = 0;

  sync_start_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en0), .master_i(ms0), .fire_i(fi0),
    .trig_n_i(line_n), .trig_oe_o(oe0),
    .tx_empty_i(txe), .tx_empty_o(txe0), .rx_we_i(rxwe), .rx_we_o(rxwe0),
    .ts_en_i(tse), .ts_en_o(tse0), .line_asserted_o(la0), .fired_o(fd0)
  );

  sync_start_gate u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en1), .master_i(1'b0), .fire_i(fi1),
    .trig_n_i(line_n), .trig_oe_o(oe1),
    .tx_empty_i(txe), .tx_empty_o(txe1), .rx_we_i(rxwe), .rx_we_o(rxwe1),
    .ts_en_i(tse), .ts_en_o(tse1), .line_asserted_o(la1), .fired_o(fd1)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // advance n rising edges, return at following falling edge
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check(fd0, 1'b0, "R1 fired after reset");
    check(la0, 1'b0, "R1 line_asserted after reset");
    check(oe0, 1'b0, "R1 trig_oe after reset");
  endtask

  task automatic t_passthrough;
    en0 = 0;
    for (int p = 0; p < 8; p++) begin
      {txe, rxwe, tse} = p[2:0];
      cyc(1);
      check(txe0, txe, "R2 tx_empty pass");
      check(rxwe0, rxwe, "R2 rx_we pass");
      check(tse0, tse, "R2 ts_en pass");
    end
  endtask

  task automatic t_hold;
    en0 = 1; ms0 = 0;
    txe = 0; rxwe = 1; tse = 1;
    cyc(2);
    check(txe0, 1'b1, "R3 tx_empty forced");
    check(rxwe0, 1'b0, "R4 rx_we held");
    check(tse0, 1'b0, "R5 ts_en held");
  endtask

  task automatic t_ext_trigger;
    ext_low = 1;
    cyc(1);
    check(la0, 1'b0, "R7 line_asserted after 1 edge");
    cyc(1);
    check(la0, 1'b1, "R7 line_asserted after 2 edges");
    check(fd0, 1'b0, "R7 not fired after 2 edges");
    check(txe0, 1'b1, "R3 still held before fire");
    cyc(1);
    check(fd0, 1'b1, "R7 fired after 3 edges");
    check(txe0, 1'b0, "R9 tx released");
    check(rxwe0, 1'b1, "R9 rx released");
    check(tse0, 1'b1, "R9 ts released");
    ext_low = 0;
    cyc(4);
    check(la0, 1'b0, "R8 line back high");
    check(fd0, 1'b1, "R8 fired sticky");
    check(rxwe0, 1'b1, "R8 rx stays released");
    en0 = 0;
    cyc(1);
    check(fd0, 1'b0, "R8 fired cleared by disarm");
    en0 = 1;
    cyc(1);
    check(txe0, 1'b1, "R3 held again after rearm");
  endtask

  task automatic t_master_fire;
    en0 = 1; ms0 = 1; en1 = 1; fi1 = 1;
    fi0 = 1;
    cyc(1);
    check(oe0, 1'b1, "R6 master drives after fire");
    check(oe1, 1'b0, "R6 slave never drives");
    cyc(2);
    check(la0, 1'b1, "R10 master line_asserted");
    check(fd0, 1'b0, "R10 master not yet fired");
    check(fd1, 1'b0, "R10 slave not yet fired");
    cyc(1);
    check(fd0, 1'b1, "R10 master fired");
    check(fd1, 1'b1, "R10 slave fired same cycle");
    check(rxwe1, 1'b1, "R9 slave rx released");
    fi0 = 0;
    cyc(1);
    check(oe0, 1'b0, "R6 drive drops after fire clear");
    en0 = 0; en1 = 0; fi1 = 0;
    fi0 = 1;
    cyc(2);
    check(oe0, 1'b0, "R6 disabled master does not drive");
    fi0 = 0; ms0 = 0;
    cyc(4);
  endtask

  task automatic t_low_while_disabled;
    en0 = 0;
    ext_low = 1;
    cyc(4);
    check(fd0, 1'b0, "R11 no fire while disabled");
    check(la0, 1'b1, "R11 line seen low");
    en0 = 1;
    #0;
    check(txe0, 1'b1, "R3 held on enable with line low");
    cyc(1);
    check(fd0, 1'b1, "R11 fires one edge after enable");
    ext_low = 0;
    en0 = 0;
    cyc(3);
  endtask

  int cycles = 0;
  bit done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_passthrough();
    t_hold();
    t_ext_trigger();
    en0 = 0;
    cyc(3);
    t_master_fire();
    t_low_while_disabled();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule